// File: doc/BRIEF.md
# Broadcast Scalar Column Update

This stage applies one reflection step to the columns of a matrix that is being triangularized. The columns arrive one element per beat. The first column of each problem is the pivot column. The stage keeps that column internally and does not forward it. For every later column, an upstream inner-product stage supplies one complex scalar Φ. The stage multiplies Φ by a per-problem complex constant θ to form a single coefficient β. That β is then applied to every element of the column: each element x becomes x + β·v, where v is the pivot element on the same row.

A small element FIFO sits in front of the update logic. A column can therefore arrive ahead of its Φ and wait until its β is ready. β is captured once and held while all rows of its column pass. The next Φ is taken only after that column's last row has left. θ is loaded through a plain strobe. It only affects β values formed after the load.

Top module: `bcast_col_update`

## Requirements
- R1: After reset, `out_valid` is 0, `col_ready` is 1 and `phi_ready` is 1.
- R2: A problem is `COLS` columns of `ROWS` elements each. Column 0 of every problem is stored as the pivot and produces no output. Each problem therefore yields exactly `(COLS-1)*ROWS` output elements.
- R3: A complex word packs the real part in bits [2W-1:W] and the imaginary part in bits [W-1:0]. Both are two's complement with `FRAC` fractional bits. For column j ≥ 1 the output element on row i equals x(i,j) + β_j·v(i), and β_j = Φ_j·θ.
- R4: Each complex product part is formed exactly, shifted right arithmetically by `FRAC` bits (rounding toward minus infinity), and clamped to the W-bit signed range. The final sum is clamped in the same way.
- R5: A held β is never replaced while its column is still flowing: `phi_ready` stays 0 from the accepting edge until the column's last row has been sent. No element of a non-pivot column is output before its β exists.
- R6: `out_last` is 1 exactly on the row `ROWS-1` element of each output column.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values and `out_valid` stays 1. No element is lost or duplicated.
- R8: The element FIFO accepts up to `DEPTH` waiting elements. When it is full, `col_ready` is 0.
- R9: A `theta_load` pulse changes only the β values captured from Φ words accepted after it. A β that is already held keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| theta_load | input | 1 | Strobe that captures `theta_in` |
| theta_in | input | 2*W | Per-problem complex constant θ |
| col_valid | input | 1 | Column element offered |
| col_ready | output | 1 | FIFO can take an element |
| col_data | input | 2*W | Column element, complex |
| phi_valid | input | 1 | Φ for the next column offered |
| phi_ready | output | 1 | No β is held; Φ can be taken |
| phi_data | input | 2*W | Complex Φ |
| out_valid | output | 1 | Updated element available |
| out_ready | input | 1 | Downstream takes the element |
| out_data | output | 2*W | Updated complex element |
| out_last | output | 1 | Final row of an output column |

Back-pressure follows valid/ready rules on all three streams. A transfer happens on a rising edge where both valid and ready are 1. A source keeps its data stable until the transfer happens. `col_ready` and `phi_ready` depend only on internal state.

## Verification
The bench varies several things:
- It changes θ between consecutive columns of one problem. A design that reads θ live rather than snapshotting it would corrupt the rows of the column still in flight.
- It uses full-scale operands so that both β and the final sum overflow in both directions. Wrapping arithmetic, or rounding toward zero, would show up as wrong values.
- It holds Φ back until the FIFO fills. This shows whether a non-pivot column leaks out without its β and whether `col_ready` drops at depth.
- It applies random output stalls. These catch data that changes under back-pressure, and elements that are dropped or counted twice. A miscount would also move `out_last` or forward the pivot column.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  typedef enum logic {
    COL_PIVOT  = 1'b0,
    COL_TARGET = 1'b1
  } col_kind_e;

  // clamp a wide signed value into a w-bit signed range
  function automatic logic signed [63:0] clamp_to(input logic signed [63:0] v,
                                                  input int unsigned w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi)      return hi;
    else if (v < lo) return lo;
    else             return v;
  endfunction

  // one part of a complex product: a*b -/+ c*d, floor-shifted and clamped
  function automatic logic signed [63:0] prod_part(input logic signed [63:0] a,
                                                   input logic signed [63:0] b,
                                                   input logic signed [63:0] c,
                                                   input logic signed [63:0] d,
                                                   input logic               sub,
                                                   input int unsigned        frac,
                                                   input int unsigned        w);
    logic signed [63:0] acc;
    acc = sub ? (a * b - c * d) : (a * b + c * d);
    return clamp_to(acc >>> frac, w);
  endfunction

endpackage

// File: rtl/bcu_fifo.sv
module bcu_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_pop,
  output logic [DW-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push;

  assign in_ready  = (cnt != CW'(DEPTH));
  assign push      = in_valid & in_ready;
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push)    wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (out_pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, out_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    out_pop |-> out_valid); // R8
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH)) |-> !in_ready); // R8

endmodule

// File: rtl/bcu_beta.sv
module bcu_beta
  import bcu_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           theta_load,
  input  logic [2*W-1:0] theta_in,
  input  logic           phi_valid,
  output logic           phi_ready,
  input  logic [2*W-1:0] phi_in,
  input  logic           release_i,
  output logic [2*W-1:0] beta_o,
  output logic           beta_full_o
);
  logic [2*W-1:0]     theta_q;
  logic [2*W-1:0]     beta_q;
  logic               beta_full_q;
  logic signed [W-1:0] phi_p [2];
  logic signed [W-1:0] th_p  [2];
  logic signed [W-1:0] nxt_p [2];
  logic               phi_fire;

  assign phi_p[0] = phi_in[2*W-1:W];
  assign phi_p[1] = phi_in[W-1:0];
  assign th_p[0]  = theta_q[2*W-1:W];
  assign th_p[1]  = theta_q[W-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_part
    if (g == 0) begin : g_re
      assign nxt_p[g] = W'(prod_part(phi_p[0], th_p[0], phi_p[1], th_p[1], 1'b1, FRAC, W));
    end else begin : g_im
      assign nxt_p[g] = W'(prod_part(phi_p[0], th_p[1], phi_p[1], th_p[0], 1'b0, FRAC, W));
    end
  end

  assign phi_ready   = ~beta_full_q;
  assign phi_fire    = phi_valid & phi_ready;
  assign beta_o      = beta_q;
  assign beta_full_o = beta_full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      theta_q     <= '0;
      beta_q      <= '0;
      beta_full_q <= 1'b0;
    end else begin
      if (theta_load) theta_q <= theta_in;
      if (release_i) begin
        beta_full_q <= 1'b0;
      end else if (phi_fire) begin
        beta_q      <= {nxt_p[0], nxt_p[1]};
        beta_full_q <= 1'b1;
      end
    end
  end

  AST_BETA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (beta_full_q && !release_i) |=> (beta_full_q && $stable(beta_q))); // R5
  AST_RELEASE_NEEDS_BETA: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> beta_full_q); // R5
  AST_THETA_NO_REACH: assert property (@(posedge clk) disable iff (!rst_n)
    (theta_load && beta_full_q && !release_i) |=> $stable(beta_q)); // R9

endmodule

// File: rtl/bcu_update.sv
module bcu_update
  import bcu_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 14,
  parameter int ROWS = 8,
  parameter int COLS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           head_valid,
  input  logic [2*W-1:0] head_data,
  output logic           head_pop,
  input  logic [2*W-1:0] beta_i,
  input  logic           beta_full_i,
  output logic           col_done_o,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_data,
  output logic           out_last
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

  logic [RW-1:0]       ridx;
  logic [CW-1:0]       cidx;
  logic [2*W-1:0]      piv [ROWS];
  col_kind_e           kind;
  logic                adv, load_out, last_row;
  logic                out_valid_q, out_last_q;
  logic [2*W-1:0]      out_data_q;
  logic [2*W-1:0]      piv_rd;
  logic signed [W-1:0] b_p [2];
  logic signed [W-1:0] v_p [2];
  logic signed [W-1:0] x_p [2];
  logic signed [W-1:0] prd [2];
  logic signed [W-1:0] sum [2];

  assign kind     = (cidx == '0) ? COL_PIVOT : COL_TARGET;
  assign last_row = (ridx == RW'(ROWS - 1));
  assign adv      = out_ready | ~out_valid_q;
  assign load_out = head_valid & (kind == COL_TARGET) & beta_full_i & adv;
  assign head_pop = head_valid & ((kind == COL_PIVOT) | (beta_full_i & adv));
  assign col_done_o = load_out & last_row;
  assign piv_rd   = piv[ridx];

  assign b_p[0] = beta_i[2*W-1:W];
  assign b_p[1] = beta_i[W-1:0];
  assign v_p[0] = piv_rd[2*W-1:W];
  assign v_p[1] = piv_rd[W-1:0];
  assign x_p[0] = head_data[2*W-1:W];
  assign x_p[1] = head_data[W-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_part
    if (g == 0) begin : g_re
      assign prd[g] = W'(prod_part(b_p[0], v_p[0], b_p[1], v_p[1], 1'b1, FRAC, W));
    end else begin : g_im
      assign prd[g] = W'(prod_part(b_p[0], v_p[1], b_p[1], v_p[0], 1'b0, FRAC, W));
    end
    assign sum[g] = W'(clamp_to(64'(x_p[g]) + 64'(prd[g]), W));
  end

  always_ff @(posedge clk) begin
    if (head_pop && kind == COL_PIVOT) piv[ridx] <= head_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ridx        <= '0;
      cidx        <= '0;
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
      out_data_q  <= '0;
    end else begin
      if (head_pop) begin
        if (last_row) begin
          ridx <= '0;
          cidx <= (cidx == CW'(COLS - 1)) ? '0 : cidx + 1'b1;
        end else begin
          ridx <= ridx + 1'b1;
        end
      end
      if (load_out) begin
        out_valid_q <= 1'b1;
        out_data_q  <= {sum[0], sum[1]};
        out_last_q  <= last_row;
      end else if (out_ready) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign out_last  = out_last_q;

  AST_OUT_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_q && !out_ready) |=> (out_valid_q && $stable(out_data_q) && $stable(out_last_q))); // R7
  AST_UPDATE_NEEDS_BETA: assert property (@(posedge clk) disable iff (!rst_n)
    (head_pop && kind == COL_TARGET) |-> beta_full_i); // R5
  AST_PIVOT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (head_pop && kind == COL_PIVOT && !out_valid_q) |=> !out_valid_q); // R2
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ridx <= RW'(ROWS - 1)); // R6

endmodule

// File: rtl/bcast_col_update.sv
module bcast_col_update #(
  parameter int W     = 16,
  parameter int FRAC  = 14,
  parameter int ROWS  = 8,
  parameter int COLS  = 4,
  parameter int DEPTH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           theta_load,
  input  logic [2*W-1:0] theta_in,
  input  logic           col_valid,
  output logic           col_ready,
  input  logic [2*W-1:0] col_data,
  input  logic           phi_valid,
  output logic           phi_ready,
  input  logic [2*W-1:0] phi_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_data,
  output logic           out_last
);
  localparam int DW = 2 * W;

  logic          head_valid, head_pop, beta_full, col_done;
  logic [DW-1:0] head_data, beta;

  bcu_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (col_valid),
    .in_ready  (col_ready),
    .in_data   (col_data),
    .out_valid (head_valid),
    .out_pop   (head_pop),
    .out_data  (head_data)
  );

  bcu_beta #(.W(W), .FRAC(FRAC)) u_beta (
    .clk         (clk),
    .rst_n       (rst_n),
    .theta_load  (theta_load),
    .theta_in    (theta_in),
    .phi_valid   (phi_valid),
    .phi_ready   (phi_ready),
    .phi_in      (phi_data),
    .release_i   (col_done),
    .beta_o      (beta),
    .beta_full_o (beta_full)
  );

  bcu_update #(.W(W), .FRAC(FRAC), .ROWS(ROWS), .COLS(COLS)) u_update (
    .clk         (clk),
    .rst_n       (rst_n),
    .head_valid  (head_valid),
    .head_data   (head_data),
    .head_pop    (head_pop),
    .beta_i      (beta),
    .beta_full_i (beta_full),
    .col_done_o  (col_done),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_last    (out_last)
  );

endmodule

// File: tb/tb_bcast_col_update.sv
`timescale 1ns/1ps
module tb_bcast_col_update;
  localparam int W = 16, FRAC = 14, ROWS = 8, COLS = 4, DEPTH = 16;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic theta_load = 1'b0, col_valid = 1'b0, phi_valid = 1'b0, out_ready = 1'b1;
  logic [2*W-1:0] theta_in = '0, col_data = '0, phi_data = '0;
  logic col_ready, phi_ready, out_valid, out_last;
  logic [2*W-1:0] out_data;

  bcast_col_update #(.W(W), .FRAC(FRAC), .ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .theta_load(theta_load), .theta_in(theta_in),
    .col_valid(col_valid), .col_ready(col_ready), .col_data(col_data),
    .phi_valid(phi_valid), .phi_ready(phi_ready), .phi_data(phi_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0, n_fail = 0, ready_pct = 100, outs_seen = 0;
  string cur_tag = "R3";
  logic [2*W-1:0] exp_q[$];
  bit exp_last_q[$];
  longint xr[COLS][ROWS], xi[COLS][ROWS], fr[COLS], fi[COLS], tr[COLS], ti[COLS];

  function automatic longint sat(longint v);
    longint hi = (64'sd1 <<< (W - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  function automatic longint rnd(int r);
    return longint'($urandom_range(2 * r)) - r;
  endfunction

  task automatic check(string req, bit ok, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic gen(int mode);
    int r = (mode == 0) ? 2000 : (mode == 3) ? 32767 : 12000;
    for (int j = 0; j < COLS; j++) begin
      for (int i = 0; i < ROWS; i++) begin
        xr[j][i] = rnd(r);
        xi[j][i] = rnd(r);
      end
      fr[j] = (mode == 3) ? rnd(32767) : rnd(16000);
      fi[j] = (mode == 3) ? rnd(32767) : rnd(16000);
    end
    tr[0] = (mode == 0) ? 8192 : (mode == 3) ? rnd(32767) : rnd(16000);
    ti[0] = (mode == 0) ? 4096 : (mode == 3) ? rnd(32767) : rnd(16000);
    for (int j = 1; j < COLS; j++) begin
      tr[j] = (mode == 2) ? rnd(16000) : tr[0];
      ti[j] = (mode == 2) ? rnd(16000) : ti[0];
    end
    tr[1] = tr[0];
    ti[1] = ti[0];
    if (mode == 3) begin
      // force both saturation directions
      fr[1] = 32767; fi[1] = -32768; tr[0] = 32767; ti[0] = -32767;
      tr[1] = tr[0]; ti[1] = ti[0];
      xr[0][0] = 32767; xi[0][0] = 32767; xr[1][0] = 30000; xi[1][0] = -30000;
    end
    for (int j = 1; j < COLS; j++) begin
      longint br, bi;
      br = sat((fr[j] * tr[j] - fi[j] * ti[j]) >>> FRAC);
      bi = sat((fr[j] * ti[j] + fi[j] * tr[j]) >>> FRAC);
      for (int i = 0; i < ROWS; i++) begin
        longint pr, pim;
        pr  = sat((br * xr[0][i] - bi * xi[0][i]) >>> FRAC);
        pim = sat((br * xi[0][i] + bi * xr[0][i]) >>> FRAC);
        exp_q.push_back({W'(sat(xr[j][i] + pr)), W'(sat(xi[j][i] + pim))});
        exp_last_q.push_back(i == ROWS - 1);
      end
    end
  endtask

  task automatic send_cols();
    for (int j = 0; j < COLS; j++)
      for (int i = 0; i < ROWS; i++) begin
        bit ok;
        col_data  = {W'(xr[j][i]), W'(xi[j][i])};
        col_valid = 1'b1;
        forever begin
          ok = col_ready;
          @(negedge clk);
          if (ok) break;
        end
        col_valid = 1'b0;
      end
  endtask

  task automatic send_phis(int delay);
    repeat (delay) @(negedge clk);
    for (int j = 1; j < COLS; j++) begin
      bit ok;
      theta_in   = {W'(tr[j]), W'(ti[j])};
      theta_load = 1'b1;
      @(negedge clk);
      theta_load = 1'b0;
      phi_data   = {W'(fr[j]), W'(fi[j])};
      phi_valid  = 1'b1;
      forever begin
        ok = phi_ready;
        @(negedge clk);
        if (ok) break;
      end
      phi_valid = 1'b0;
    end
  endtask

  task automatic drain_and_count();
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
    check("R2 output count", outs_seen == (COLS - 1) * ROWS, outs_seen, (COLS - 1) * ROWS);
    outs_seen = 0;
  endtask

  task automatic run_problem(int mode, int pct, string tag);
    ready_pct = pct;
    cur_tag = tag;
    gen(mode);
    fork
      send_cols();
      send_phis(0);
    join
    drain_and_count();
  endtask

  // per-clock reference comparison and output back-pressure
  bit stall_prev = 0, last_prev = 0;
  logic [2*W-1:0] data_prev = '0;
  always @(negedge clk) begin : monitor
    bit r;
    if (rst_n) begin
      r = ($urandom % 100) < ready_pct;
      if (stall_prev) begin
        check("R7 stall hold", out_valid && out_data == data_prev && out_last == last_prev,
              out_data, data_prev);
      end
      if (out_valid && r) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected output", 1'b0, out_data, 0);
        end else begin
          logic [2*W-1:0] e;
          bit el;
          e  = exp_q.pop_front();
          el = exp_last_q.pop_front();
          check(cur_tag, out_data == e, out_data, e);
          check("R6 last flag", out_last == el, out_last, el);
        end
        outs_seen++;
      end
      stall_prev = out_valid && !r;
      data_prev  = out_data;
      last_prev  = out_last;
      out_ready  = r;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid", out_valid == 1'b0, out_valid, 0);
    check("R1 col_ready", col_ready == 1'b1, col_ready, 1);
    check("R1 phi_ready", phi_ready == 1'b1, phi_ready, 1);

    run_problem(0, 100, "R3 basic");
    run_problem(1, 50, "R3 random stall");
    run_problem(1, 100, "R3 second problem");
    run_problem(2, 70, "R9 theta per column");
    run_problem(3, 60, "R4 saturation");
    run_problem(3, 100, "R4 saturation full rate");

    // FIFO fills while phi is held back
    ready_pct = 100;
    cur_tag = "R8 held column";
    gen(1);
    fork
      send_cols();
      send_phis(80);
      begin
        repeat (60) @(negedge clk);
        check("R8 col_ready low when full", col_ready == 1'b0, col_ready, 0);
        check("R5 no output without beta", out_valid == 1'b0, out_valid, 0);
      end
    join
    drain_and_count();

    run_problem(2, 40, "R9 theta with stalls");
    finish_run();
  end

endmodule